// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a register-access slave for a serial bus with one shared data line, a serial clock and an active-low select. Every transaction is framed by a select low period. It opens with a 16-bit command word, carries one to eight 16-bit data words, and may close with a check word. The block decodes the command, writes or reads a small register file word by word, steps the register address when asked, and runs a self-reset when a write to the configuration register sets the reset bit.

All bus inputs are brought into the system clock domain through synchronizers, and all bus edges are found there. The serial clock must therefore stay high and low for at least four system clocks each. The data line is presented as three plain signals: the sampled input, the output value and the output enable. The pad itself lies outside the block. The serial bus has no back-pressure: the master owns all timing, and the slave keeps pace at any legal serial clock rate. The serial clock idles low.

Top module: `spi3w_reg_slave`

## Requirements
- R1: Input bits are taken on rising serial clock edges, most significant bit first. Output bits change only after falling serial clock edges, so the line is stable whenever the clock is high.
- R2: The command word holds these fields: bit 15 enables the check word, bits 14:12 hold the block length minus one, bit 11 enables auto-increment, bit 10 selects a read (1) or a write (0), bits 7:0 give the start address, and bits 9:8 are ignored. Exactly the stated number of data words follows.
- R3: With auto-increment set, each data word uses the next address (wrapping at 8 bits). With it clear, every word of the block uses the start address.
- R4: Without a check word, each write word is committed at its own 16th rising edge. A word cut short by select rising is dropped, and the words before it stay committed.
- R5: With the check word enabled on a write, all data words are held back. They are committed in order only if bits 7:0 of the check word equal the CRC-8 (polynomial 0x07, start value 0xFF, fed MSB first) over the command and data words. Bits 15:8 of the check word are ignored.
- R6: With the check word enabled on a read, the slave sends a final word of 0x00 in bits 15:8 and, in bits 7:0, the CRC-8 over the command word and the data words it sent.
- R7: A write of a value with bit 15 set to the configuration register (address 0) resets the block at once: all registers read back as zero afterwards.
- R8: After a self-reset, the slave ignores the bus, including complete commands, until the select line falls again. From that point it works normally.
- R9: Data words that follow the reset word in the same burst have no effect.
- R10: The output enable is high only during the data and check words of a read. It is never high while the internal reset runs.
- R11: After the system reset, the output enable is low and every register reads as zero.
- R12: Addresses at or above the register count read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low transaction select |
| sio_in | input | 1 | Value sensed on the shared data line |
| sio_out | output | 1 | Value the slave drives on the data line |
| sio_oe | output | 1 | High when the slave drives the data line |

## Verification
A wrong bit counter or phase shows up at once as a misaligned read word or a write landing in the wrong register. It becomes visible on the very next read-back. A stale address after auto-increment corrupts the second word of a burst. A CRC state fed on the wrong edge shows up only in the check word of a CRC read, or as a rejected good write, within one transaction. A reset or lockout flag stuck in the wrong state is caught at the ports within one word: either the line is driven during an ignored command, or a fresh transaction after the select falls receives no response.

// File: rtl/sio3_pkg.sv
`timescale 1ns/1ps
package sio3_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 3;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_CRC, PH_DONE} phase_e;

  typedef struct packed {
    logic             crc_en;
    logic [LEN_W-1:0] len_m1;
    logic             auto_inc;
    logic             rd;
    logic [7:0]       addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.crc_en   = w[15];
    c.len_m1   = w[14:12];
    c.auto_inc = w[11];
    c.rd       = w[10];
    c.addr     = w[7:0];
    return c;
  endfunction

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    return {c[6:0], 1'b0} ^ ((c[7] ^ b) ? 8'h07 : 8'h00);
  endfunction
endpackage

// File: rtl/sio3_edge_sync.sv
`timescale 1ns/1ps
module sio3_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sio_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_high,
  output logic din
);
  logic [SYNC:0]   sclk_p;
  logic [SYNC:0]   cs_p;
  logic [SYNC-1:0] din_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      din_p  <= {din_p[SYNC-2:0], sio_in};
    end
  end

  assign sclk_rise = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign sclk_fall = ~sclk_p[SYNC-1] & sclk_p[SYNC];
  assign cs_fall   = ~cs_p[SYNC-1] & cs_p[SYNC];
  assign cs_high   = cs_p[SYNC-1];
  assign din       = din_p[SYNC-1];
endmodule

// File: rtl/sio3_reset_seq.sv
`timescale 1ns/1ps
module sio3_reset_seq #(
  parameter int RST_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_req,
  input  logic cs_fall,
  output logic rst_busy,
  output logic locked,
  output logic hold
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      rst_busy <= 1'b0;
      locked   <= 1'b0;
    end else if (soft_req) begin
      cnt      <= CW'(RST_CYCLES - 1);
      rst_busy <= 1'b1;
      locked   <= 1'b1;
    end else if (rst_busy) begin
      if (cnt == '0) rst_busy <= 1'b0;
      else           cnt      <= cnt - 1'b1;
    end else if (locked && cs_fall) begin
      locked <= 1'b0;
    end
  end

  // engine stays idle while locked, except on the unlocking select edge
  assign hold = rst_busy | (locked & ~cs_fall);
endmodule

// File: rtl/sio3_regfile.sv
`timescale 1ns/1ps
module sio3_regfile #(
  parameter int N_REGS = 8,
  parameter int W      = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [7:0]   waddr,
  input  logic [W-1:0] wdata,
  input  logic [7:0]   raddr,
  output logic [W-1:0] rdata
);
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  logic [W-1:0] word_arr [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (clr)                        q <= '0;
      else if (we && waddr == 8'(i))       q <= wdata;
    end
    assign word_arr[i] = q;
  end

  assign rdata = ({1'b0, raddr} < 9'(N_REGS)) ? word_arr[raddr[AW-1:0]] : '0;
endmodule

// File: rtl/sio3_frame_engine.sv
`timescale 1ns/1ps
module sio3_frame_engine
  import sio3_pkg::*;
#(
  parameter int STAGE_D = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_high,
  input  logic              din,
  input  logic [WORD_W-1:0] rdata,
  output logic [7:0]        raddr,
  output logic              we,
  output logic [7:0]        waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              sio_out,
  output logic              sio_oe
);
  localparam int SW = $clog2(STAGE_D + 1);
  localparam int IW = $clog2(STAGE_D);

  logic              active;
  phase_e            phase;
  logic [3:0]        bitcnt;
  logic [WORD_W-1:0] rx_sr, tx_sr;
  cmd_t              cmd;
  logic [7:0]        addr;
  logic [LEN_W-1:0]  words_left;
  logic [7:0]        crc;
  logic [7:0]        stage_addr [STAGE_D];
  logic [WORD_W-1:0] stage_data [STAGE_D];
  logic [SW-1:0]     stage_cnt, drain_left;
  logic [IW-1:0]     drain_idx;
  logic              draining;

  logic [WORD_W-1:0] next_word;
  logic              word_done;
  logic [7:0]        addr_nxt;
  logic              tx_phase;

  assign next_word = {rx_sr[WORD_W-2:0], din};
  assign word_done = sclk_rise && bitcnt == 4'd15;
  assign addr_nxt  = cmd.auto_inc ? addr + 8'd1 : addr;
  assign raddr     = (phase == PH_CMD) ? next_word[7:0] : addr_nxt;
  assign tx_phase  = active && cmd.rd && (phase == PH_DATA || phase == PH_CRC);
  assign sio_oe    = tx_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= PH_CMD; bitcnt <= '0; rx_sr <= '0; tx_sr <= '0;
      cmd <= '0; addr <= '0; words_left <= '0; crc <= 8'hFF;
      stage_cnt <= '0; drain_left <= '0; drain_idx <= '0; draining <= 1'b0;
      we <= 1'b0; waddr <= '0; wdata <= '0; sio_out <= 1'b0;
    end else if (hold) begin
      active   <= 1'b0;
      draining <= 1'b0;
      we       <= 1'b0;
    end else begin
      we <= 1'b0;
      if (draining) begin
        we        <= 1'b1;
        waddr     <= stage_addr[drain_idx];
        wdata     <= stage_data[drain_idx];
        drain_idx <= drain_idx + 1'b1;
        drain_left <= drain_left - 1'b1;
        if (drain_left == SW'(1)) draining <= 1'b0;
      end
      if (cs_fall) begin
        active    <= 1'b1;
        phase     <= PH_CMD;
        bitcnt    <= '0;
        crc       <= 8'hFF;
        stage_cnt <= '0;
      end else if (cs_high) begin
        active <= 1'b0;
      end else if (active) begin
        if (sclk_rise && phase != PH_DONE) begin
          rx_sr  <= next_word;
          bitcnt <= bitcnt + 4'd1;
          if (phase == PH_CMD || (phase == PH_DATA && !cmd.rd))
            crc <= crc8_step(crc, din);
          if (word_done) begin
            unique case (phase)
              PH_CMD: begin
                cmd        <= decode_cmd(next_word);
                addr       <= next_word[7:0];
                words_left <= next_word[14:12];
                tx_sr      <= rdata;
                phase      <= PH_DATA;
              end
              PH_DATA: begin
                if (!cmd.rd) begin
                  if (cmd.crc_en) begin
                    stage_addr[stage_cnt[IW-1:0]] <= addr;
                    stage_data[stage_cnt[IW-1:0]] <= next_word;
                    stage_cnt <= stage_cnt + 1'b1;
                  end else begin
                    we    <= 1'b1;
                    waddr <= addr;
                    wdata <= next_word;
                  end
                end else begin
                  tx_sr <= rdata;
                end
                addr <= addr_nxt;
                if (words_left == '0) begin
                  phase <= cmd.crc_en ? PH_CRC : PH_DONE;
                  if (cmd.rd && cmd.crc_en) tx_sr <= {8'h00, crc};
                end else begin
                  words_left <= words_left - 1'b1;
                end
              end
              PH_CRC: begin
                if (!cmd.rd && next_word[7:0] == crc && stage_cnt != '0) begin
                  draining   <= 1'b1;
                  drain_idx  <= '0;
                  drain_left <= stage_cnt;
                end
                phase <= PH_DONE;
              end
              default: phase <= PH_DONE;
            endcase
          end
        end
        if (sclk_fall && tx_phase) begin
          sio_out <= tx_sr[WORD_W-1];
          tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
          if (phase == PH_DATA) crc <= crc8_step(crc, tx_sr[WORD_W-1]);
        end
      end
    end
  end
endmodule

// File: rtl/spi3w_reg_slave.sv
`timescale 1ns/1ps
module spi3w_reg_slave
  import sio3_pkg::*;
#(
  parameter int N_REGS      = 8,
  parameter int CFG_ADDR    = 0,
  parameter int SRST_BIT    = 15,
  parameter int RST_CYCLES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sio_in,
  output logic sio_out,
  output logic sio_oe
);
  logic sclk_rise, sclk_fall, cs_fall, cs_high, din;
  logic rst_busy, bus_locked, hold, soft_req;
  logic we;
  logic [7:0] waddr, raddr;
  logic [WORD_W-1:0] wdata, rdata;

  sio3_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sio_in(sio_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_high(cs_high), .din(din)
  );

  assign soft_req = we && waddr == 8'(CFG_ADDR) && wdata[SRST_BIT];

  sio3_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .soft_req(soft_req), .cs_fall(cs_fall),
    .rst_busy(rst_busy), .locked(bus_locked), .hold(hold)
  );

  sio3_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_high(cs_high), .din(din),
    .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
    .sio_out(sio_out), .sio_oe(sio_oe)
  );

  sio3_regfile #(.N_REGS(N_REGS), .W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(rst_busy), .we(we), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/sio3_checker.sv
`timescale 1ns/1ps
module sio3_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic sio_out,
  input logic sio_oe,
  input logic rst_busy,
  input logic bus_locked
);
  // R1: driven value moves only while the serial clock is low
  a_r1_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe && $past(sio_oe) && !$stable(sio_out)) |-> !sclk);

  // R10: never drive while the internal reset runs
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> !sio_oe);

  // R10: driving starts only inside a selected transaction
  a_r10_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sio_oe) |-> !cs_n);

  // R8: no driving while the bus is locked out
  a_r8_quiet_locked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_locked |-> !sio_oe);

  // R8: the lockout outlives the reset pulse
  a_r8_lock_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> bus_locked);

  // R7: self-reset lasts more than one cycle once started
  a_r7_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_busy) |=> rst_busy);
endmodule

bind spi3w_reg_slave sio3_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out),
  .sio_oe(sio_oe), .rst_busy(rst_busy), .bus_locked(bus_locked)
);

// File: tb/sim_spi3w_reg_slave.sv
`timescale 1ns/1ps
module sim_spi3w_reg_slave;
  localparam int NR = 8;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sio_in = 1'b0;
  logic sio_out, sio_oe;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] model [NR];
  logic [15:0] exp_q[$], act_q[$], wq[$];
  string tag_q[$];

  always #2 clk = ~clk;

  spi3w_reg_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_word(input logic [7:0] c, input logic [15:0] w);
    logic [7:0] r = c;
    for (int i = 15; i >= 0; i--) r = {r[6:0], 1'b0} ^ ((r[7] ^ w[i]) ? 8'h07 : 8'h00);
    return r;
  endfunction

  function automatic logic [15:0] mk_cmd(input logic ce, input int n, input logic ai,
                                         input logic rd, input logic [7:0] a);
    return {ce, 3'(n - 1), ai, rd, 2'b11, a};
  endfunction

  function automatic logic [15:0] mread(input logic [7:0] a);
    return (a < NR) ? model[a[2:0]] : 16'h0000;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [15:0] d);
    if (a < NR) model[a[2:0]] = d;
  endtask

  task automatic send_bits(input logic [15:0] w, input int nb, output logic [15:0] r,
                           output logic oe_any, output logic oe_all);
    r = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 15; i > 15 - nb; i--) begin
      sio_in = w[i];
      repeat (H) @(negedge clk);
      r[i] = sio_out; oe_any |= sio_oe; oe_all &= sio_oe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send_word(input logic [15:0] w, output logic [15:0] r,
                           output logic oa, output logic ol);
    send_bits(w, 16, r, oa, ol);
  endtask

  task automatic sel;
    cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic desel;
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (24) @(negedge clk);
  endtask

  // crcm: 0 none, 1 good check word, 2 bad check word; data in wq
  task automatic do_write(input logic [7:0] a, input logic ai, input int crcm);
    logic [15:0] c, r; logic [7:0] crc, p; logic oa, ol;
    c = mk_cmd(crcm != 0, wq.size(), ai, 1'b0, a);
    crc = crc_word(8'hFF, c);
    sel; send_word(c, r, oa, ol);
    p = a;
    foreach (wq[i]) begin
      send_word(wq[i], r, oa, ol);
      crc = crc_word(crc, wq[i]);
      if (crcm == 0) mwrite(p, wq[i]);
      if (ai) p++;
    end
    if (crcm != 0) begin
      send_word({8'h5A, (crcm == 1) ? crc : ~crc}, r, oa, ol);
      if (crcm == 1) begin
        p = a;
        foreach (wq[i]) begin mwrite(p, wq[i]); if (ai) p++; end
      end
    end
    desel;
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input logic ai,
                         input logic ce, input string tag);
    logic [15:0] c, r, e; logic [7:0] crc, p; logic oa, ol;
    c = mk_cmd(ce, n, ai, 1'b1, a);
    crc = crc_word(8'hFF, c);
    sel; send_word(c, r, oa, ol);
    chk({tag, " R10 no drive in command"}, 16'(oa), 16'h0);
    p = a;
    for (int i = 0; i < n; i++) begin
      e = mread(p);
      crc = crc_word(crc, e);
      exp_q.push_back(e); tag_q.push_back({tag, " R1 data"});
      send_word(16'h0000, r, oa, ol);
      act_q.push_back(r);
      chk({tag, " R10 drive in data"}, 16'(ol), 16'h1);
      if (ai) p++;
    end
    if (ce) begin
      exp_q.push_back({8'h00, crc}); tag_q.push_back({tag, " R6 crc word"});
      send_word(16'h0000, r, oa, ol);
      act_q.push_back(r);
    end
    desel;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; logic oa, ol;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 oe after reset", 16'(sio_oe), 16'h0);
    do_read(8'h00, 8, 1'b1, 1'b0, "R11 reset values");

    wq = {16'hBEEF};
    do_write(8'h02, 1'b0, 0);
    do_read(8'h02, 1, 1'b0, 1'b0, "R2 single");

    wq = {16'h1111, 16'h2222, 16'h3333, 16'h4444};
    do_write(8'h04, 1'b1, 0);
    do_read(8'h04, 4, 1'b1, 1'b0, "R3 burst inc");
    do_read(8'h06, 4, 1'b1, 1'b0, "R12 past end");

    wq = {16'hA1A1, 16'hA2A2, 16'hA3A3};
    do_write(8'h01, 1'b0, 0);
    do_read(8'h01, 3, 1'b0, 1'b0, "R3 fixed addr");

    wq = {16'h7777};
    do_write(8'h20, 1'b0, 0);
    do_read(8'h20, 1, 1'b0, 1'b0, "R12 unmapped");
    do_read(8'h00, 1, 1'b0, 1'b0, "R12 no alias");

    // R4: second word cut short by deselect
    sel;
    send_word(mk_cmd(1'b0, 2, 1'b1, 1'b0, 8'h03), r, oa, ol);
    send_word(16'h5A5A, r, oa, ol);
    mwrite(8'h03, 16'h5A5A);
    send_bits(16'hC3C3, 10, r, oa, ol);
    desel;
    do_read(8'h03, 2, 1'b1, 1'b0, "R4 partial word");

    wq = {16'h0F0F, 16'hF0F0};
    do_write(8'h03, 1'b1, 1);
    do_read(8'h03, 2, 1'b1, 1'b1, "R5 good crc");
    wq = {16'h0001, 16'h0002};
    do_write(8'h03, 1'b1, 2);
    do_read(8'h03, 2, 1'b1, 1'b1, "R5 bad crc");
    do_read(8'h05, 3, 1'b0, 1'b1, "R6 fixed crc");

    // R7/R9/R8: reset inside a burst, then commands with select held low
    sel;
    send_word(mk_cmd(1'b0, 3, 1'b1, 1'b0, 8'h00), r, oa, ol);
    send_word(16'h8000, r, oa, ol);
    for (int i = 0; i < NR; i++) model[i] = '0;
    send_word(16'h1234, r, oa, ol);
    send_word(16'h5678, r, oa, ol);
    send_word(mk_cmd(1'b0, 1, 1'b0, 1'b0, 8'h02), r, oa, ol);
    send_word(16'hDEAD, r, oa, ol);
    send_word(mk_cmd(1'b0, 1, 1'b0, 1'b1, 8'h02), r, oa, ol);
    send_word(16'h0000, r, oa, ol);
    chk("R8 ignored read not driven", 16'(oa), 16'h0);
    desel;
    do_read(8'h00, 8, 1'b1, 1'b0, "R7 R9 cleared");

    wq = {16'h0C0C};
    do_write(8'h02, 1'b0, 0);
    do_read(8'h02, 1, 1'b0, 1'b0, "R8 resumed");

    repeat (10) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule